// File: doc/BRIEF.md
# Multi-core boot hold controller

This block sits on a simple 32-bit register bus and decides when each of up to two processor cores may leave reset. After a system reset, any core whose hold bit is set stays in a waiting state. Software releases a waiting core by writing a 0 over a hold bit that currently reads 1. The block then raises a one-cycle release pulse for that core, which puts the core through a fresh reset and boot, and sets the core's run enable.

Each core also has a programmable initial vector table base. Writing this register has no effect on a core that is already running. The register value is copied into the core's boot-vector output only when that core is released, so the core samples the new base the next time it comes out of reset.

A parameter selects a dual-core or a single-core build. Read-only identification words are also decoded. Accesses to any other offset complete with zero read data and a one-cycle error flag.

Top module: `boot_hold_ctrl`

## Requirements
- R1: After reset, the hold register at offset 0x000 reads 2 in the dual-core build (core 1 held, core 0 running) and 0 in the single-core build. `core_run` is the complement of the hold bits. Every vector base register and every `core_boot_vec` output holds 0x1000_0000. `core_rel_pulse` and `bus_err` are 0.
- R2: When a write to offset 0x000 takes a hold bit from 1 to 0, the following happens on the clock edge that captures the write: `core_rel_pulse` goes high for that core for exactly one cycle, `core_run` for that core goes high, and that core's `core_boot_vec` takes the core's current vector base value.
- R3: Writing 1 to the hold bit of a running core stores the bit, which then reads back as 1. The core's `core_run` stays high and no pulse is produced. A later write of 0 to that bit releases the core again.
- R4: Writing 0 to a hold bit that is already 0 produces no release pulse.
- R5: A single write that clears two set hold bits releases both cores in the same cycle.
- R6: The vector base registers are at offset 0x004 (core 0) and 0x008 (core 1), and they read back what was written. A write to one of them leaves `core_boot_vec` unchanged until that core's next release.
- R7: Offset 0x008 exists only in the dual-core build. In the single-core build it behaves as an unmapped offset.
- R8: Offsets 0xFF0, 0xFF4, 0xFF8 and 0xFFC read 0x0D, 0xF0, 0x05 and 0xB1 in the low byte, with the upper bits at zero. Writes to these offsets change nothing and raise no error.
- R9: An access to an unmapped offset reads as zero and changes no state. It raises `bus_err` in the single cycle after the access.
- R10: Read data appears on `bus_rdata` in the cycle after the read access. Address bits 1:0 are ignored.
- R11: Asserting `rst_n` at any time returns every register and output to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Unmapped-offset error, one cycle after the access |
| core_run | output | NC (2, or 1 in the single-core build) | Per-core run enable |
| core_rel_pulse | output | NC | Per-core one-cycle release/reset pulse |
| core_boot_vec | output | 32*NC | Per-core boot vector base, core 0 in the low word |

## Verification
The bound checker watches four properties on every cycle:
- A release pulse only ever follows a bus write that cleared that core's hold bit.
- A pulsing core is always running.
- `core_run` never falls outside reset.
- A boot vector changes only together with its core's release pulse, and an error flag only follows an access.

Several behaviours need the bench's directed scenarios because they depend on concrete values:
- the reset values in both builds;
- the vector base actually being transferred at release;
- both cores being released in one write;
- identification bytes, unmapped-offset read data, and the single-core decode of offset 0x008.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_HOLD,
    ACC_VEC,
    ACC_ID,
    ACC_BAD
  } acc_kind_t;

  typedef struct packed {
    acc_kind_t  kind;
    logic [1:0] idx;
  } acc_dec_t;

  localparam logic [31:0] VEC_RST_DEFAULT = 32'h1000_0000;

  function automatic logic [7:0] id_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h0D;
      2'd1:    return 8'hF0;
      2'd2:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/bhc_decode.sv
module bhc_decode
  import bhc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NC     = 2
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output acc_dec_t          dec
);

  localparam int WORDS    = 1 << (ADDR_W - 2);
  localparam int ID_FIRST = WORDS - 4;

  logic [ADDR_W-3:0] word;
  logic              unused_lsb;

  assign word       = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    dec.kind = ACC_NONE;
    dec.idx  = '0;
    if (sel) begin
      if (word == '0) begin
        dec.kind = ACC_HOLD;
      end else if (int'(word) <= NC) begin
        dec.kind = ACC_VEC;
        dec.idx  = 2'(int'(word) - 1);
      end else if (int'(word) >= ID_FIRST) begin
        dec.kind = ACC_ID;
        dec.idx  = word[1:0];
      end else begin
        dec.kind = ACC_BAD;
      end
    end
  end

endmodule

// File: rtl/bhc_core_slice.sv
module bhc_core_slice #(
  parameter bit          HOLD_RST = 1'b0,
  parameter logic [31:0] VEC_RST  = 32'h1000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hold,
  input  logic        hold_wbit,
  input  logic        wr_vec,
  input  logic [31:0] vec_wdata,
  output logic        hold_q,
  output logic [31:0] vec_q,
  output logic        run_q,
  output logic        pulse_q,
  output logic [31:0] boot_q
);

  logic        hold_d;
  logic        run_d;
  logic        pulse_d;
  logic        release_now;
  logic [31:0] vec_d;
  logic [31:0] boot_d;

  always_comb begin
    release_now = wr_hold & hold_q & ~hold_wbit;
    hold_d      = wr_hold ? hold_wbit : hold_q;
    run_d       = run_q | release_now;
    pulse_d     = release_now;
    vec_d       = wr_vec ? vec_wdata : vec_q;
    boot_d      = release_now ? vec_q : boot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= HOLD_RST;
      run_q   <= ~HOLD_RST;
      pulse_q <= 1'b0;
      vec_q   <= VEC_RST;
      boot_q  <= VEC_RST;
    end else begin
      hold_q  <= hold_d;
      run_q   <= run_d;
      pulse_q <= pulse_d;
      vec_q   <= vec_d;
      boot_q  <= boot_d;
    end
  end

endmodule

// File: rtl/boot_hold_ctrl.sv
module boot_hold_ctrl
  import bhc_pkg::*;
#(
  parameter bit          DUAL_CORE = 1'b1,
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] VEC_RST   = VEC_RST_DEFAULT,
  localparam int         NC        = DUAL_CORE ? 2 : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic [NC-1:0]     core_run,
  output logic [NC-1:0]     core_rel_pulse,
  output logic [32*NC-1:0]  core_boot_vec
);

  acc_dec_t    dec;
  logic        wr_hold;
  logic        rd_en;
  logic [NC-1:0] hold_bits;
  logic [31:0] vec_q [NC];
  logic [31:0] rd_d;
  logic        err_d;
  logic [31:0] rdata_q;
  logic        err_q;

  bhc_decode #(
    .ADDR_W (ADDR_W),
    .NC     (NC)
  ) u_decode (
    .sel  (bus_sel),
    .addr (bus_addr),
    .dec  (dec)
  );

  assign wr_hold = bus_wr && (dec.kind == ACC_HOLD);
  assign rd_en   = bus_sel && !bus_wr;

  for (genvar i = 0; i < NC; i++) begin : g_core
    logic wr_vec_i;
    assign wr_vec_i = bus_wr && (dec.kind == ACC_VEC) && (dec.idx == 2'(i));

    bhc_core_slice #(
      .HOLD_RST (i != 0),
      .VEC_RST  (VEC_RST)
    ) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hold   (wr_hold),
      .hold_wbit (bus_wdata[i]),
      .wr_vec    (wr_vec_i),
      .vec_wdata (bus_wdata),
      .hold_q    (hold_bits[i]),
      .vec_q     (vec_q[i]),
      .run_q     (core_run[i]),
      .pulse_q   (core_rel_pulse[i]),
      .boot_q    (core_boot_vec[32*i +: 32])
    );
  end

  always_comb begin
    rd_d = '0;
    case (dec.kind)
      ACC_HOLD: rd_d = 32'(hold_bits);
      ACC_VEC: begin
        for (int i = 0; i < NC; i++) begin
          if (dec.idx == 2'(i)) rd_d = vec_q[i];
        end
      end
      ACC_ID:  rd_d = {24'b0, id_byte(dec.idx)};
      default: rd_d = '0;
    endcase
    err_d = (dec.kind == ACC_BAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rd_d;
      err_q <= err_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

endmodule

// File: rtl/boot_hold_ctrl_chk.sv
module boot_hold_ctrl_chk #(
  parameter bit DUAL_CORE = 1'b1,
  parameter int ADDR_W    = 12,
  localparam int NC       = DUAL_CORE ? 2 : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NC-1:0]     hold_wbits,
  input logic              bus_err,
  input logic [NC-1:0]     core_run,
  input logic [NC-1:0]     core_rel_pulse,
  input logic [32*NC-1:0]  core_boot_vec
);

  logic hold_wr_seen;
  logic unused_lsb;

  assign hold_wr_seen = bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == '0);
  assign unused_lsb   = ^bus_addr[1:0];

  for (genvar i = 0; i < NC; i++) begin : g_chk
    // R2
    rel_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_rel_pulse[i] |-> $past(hold_wr_seen && !hold_wbits[i]));

    // R2
    rel_pulse_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_rel_pulse[i] |-> core_run[i]);

    // R3
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_run[i] |=> core_run[i]);

    // R6
    boot_vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !core_rel_pulse[i] |-> $stable(core_boot_vec[32*i +: 32]));
  end

  // R9
  err_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel));

endmodule

bind boot_hold_ctrl boot_hold_ctrl_chk #(
  .DUAL_CORE (DUAL_CORE),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_sel        (bus_sel),
  .bus_wr         (bus_wr),
  .bus_addr       (bus_addr),
  .hold_wbits     (bus_wdata[NC-1:0]),
  .bus_err        (bus_err),
  .core_run       (core_run),
  .core_rel_pulse (core_rel_pulse),
  .core_boot_vec  (core_boot_vec)
);

// File: tb/tb_boot_hold_ctrl.sv
`timescale 1ns/1ps
module tb_boot_hold_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;

  logic [31:0] rdata, rdata_s;
  logic        err, err_s;
  logic [1:0]  run, pulse;
  logic [63:0] boot;
  logic [0:0]  run_s, pulse_s;
  logic [31:0] boot_s;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  boot_hold_ctrl #(.DUAL_CORE(1'b1)) dut (
    .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (rdata),
    .bus_err (err), .core_run (run), .core_rel_pulse (pulse),
    .core_boot_vec (boot)
  );

  boot_hold_ctrl #(.DUAL_CORE(1'b0)) dut_single (
    .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (rdata_s),
    .bus_err (err_s), .core_run (run_s), .core_rel_pulse (pulse_s),
    .core_boot_vec (boot_s)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic e,
                          output logic [31:0] ds, output logic es);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = rdata; e = err; ds = rdata_s; es = err_s;
  endtask

  task automatic t_reset_state();
    logic [31:0] d, ds; logic e, es;
    check("R1 run", run, 2'b01);
    check("R1 pulse", pulse, 2'b00);
    check("R1 boot", boot, {32'h1000_0000, 32'h1000_0000});
    check("R1 err", err, 1'b0);
    check("R1 single run", run_s, 1'b1);
    check("R1 single boot", boot_s, 32'h1000_0000);
    bus_read(12'h000, d, e, ds, es);
    check("R1 hold dual", d, 32'd2);
    check("R1 hold single", ds, 32'd0);
    bus_read(12'h008, d, e, ds, es);
    check("R1 vec1", d, 32'h1000_0000);
    check("R7 single 0x008 err", es, 1'b1);
    check("R7 single 0x008 data", ds, 32'd0);
    check("R7 dual 0x008 no err", e, 1'b0);
  endtask

  task automatic t_release();
    logic [31:0] d, ds; logic e, es;
    bus_write(12'h008, 32'h2000_0100);
    check("R6 boot1 unchanged", boot[63:32], 32'h1000_0000);
    bus_read(12'h008, d, e, ds, es);
    check("R6 vec1 readback", d, 32'h2000_0100);
    bus_write(12'h000, 32'h0);
    check("R2 pulse core1", pulse, 2'b10);
    check("R4 no pulse core0", pulse[0], 1'b0);
    check("R2 run", run, 2'b11);
    check("R2 boot1 loaded", boot[63:32], 32'h2000_0100);
    @(negedge clk);
    check("R2 pulse one cycle", pulse, 2'b00);
  endtask

  task automatic t_sticky();
    logic [31:0] d, ds; logic e, es;
    bus_write(12'h000, 32'h1);
    check("R3 no pulse on set", pulse, 2'b00);
    check("R3 run kept", run, 2'b11);
    bus_read(12'h000, d, e, ds, es);
    check("R3 hold readback", d, 32'd1);
    bus_write(12'h004, 32'h3000_0000);
    check("R6 boot0 unchanged", boot[31:0], 32'h1000_0000);
    bus_write(12'h000, 32'h0);
    check("R3 re-release pulse", pulse, 2'b01);
    check("R3 boot0 loaded", boot[31:0], 32'h3000_0000);
    check("R3 boot1 kept", boot[63:32], 32'h2000_0100);
  endtask

  task automatic t_both();
    bus_write(12'h000, 32'h3);
    check("R5 set both no pulse", pulse, 2'b00);
    bus_write(12'h000, 32'h0);
    check("R5 both pulse", pulse, 2'b11);
    check("R5 run", run, 2'b11);
  endtask

  task automatic t_unmapped();
    logic [31:0] d, ds; logic e, es;
    bus_read(12'h100, d, e, ds, es);
    check("R9 unmapped data", d, 32'd0);
    check("R9 err", e, 1'b1);
    @(negedge clk);
    check("R9 err one cycle", err, 1'b0);
    bus_write(12'h00C, 32'h3);
    check("R9 write err", err, 1'b1);
    check("R9 no pulse", pulse, 2'b00);
    bus_read(12'h000, d, e, ds, es);
    check("R9 hold untouched", d, 32'd0);
    bus_read(12'h006, d, e, ds, es);
    check("R10 low bits ignored", d, 32'h3000_0000);
  endtask

  task automatic t_id();
    logic [31:0] d, ds; logic e, es;
    logic [7:0] exp_b [4] = '{8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int k = 0; k < 4; k++) begin
      bus_read(12'hFF0 + 12'(4*k), d, e, ds, es);
      check("R8 id byte", d, {24'b0, exp_b[k]});
      check("R8 id no err", e, 1'b0);
    end
    bus_write(12'hFF0, 32'h0);
    check("R8 write no err", err, 1'b0);
    bus_read(12'hFF0, d, e, ds, es);
    check("R8 id after write", d, 32'h0D);
  endtask

  task automatic t_mid_reset();
    logic [31:0] d, ds; logic e, es;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 run", run, 2'b01);
    check("R11 pulse", pulse, 2'b00);
    check("R11 boot", boot, {32'h1000_0000, 32'h1000_0000});
    @(negedge clk);
    rst_n = 1'b1;
    bus_read(12'h000, d, e, ds, es);
    check("R11 hold", d, 32'd2);
    bus_read(12'h004, d, e, ds, es);
    check("R11 vec0", d, 32'h1000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_release();
    t_sticky();
    t_both();
    t_unmapped();
    t_id();
    t_mid_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule